// File: doc/BRIEF.md
# Partial-Response (1+D)^2 Viterbi Bit Detector

This block recovers channel bits from a read channel whose equalizer shapes each written bit into the three-tap response 1, 2, 1. This is the second-order partial-response target (1+D)^2. The block takes one signed equalized sample per symbol period. It then searches a four-state trellis for the most likely bit sequence and emits one hard decision per accepted sample, a fixed number of symbols later.

Written bits map to amplitudes: a bit of 1 stands for +1 and a bit of 0 for -1. The noiseless sample for symbol n is therefore `(2*(a[n] + 2*a[n-1] + a[n-2]) - 4) * STEP`, where `a` are the bit values 0/1 and `STEP` is the sample value of one amplitude unit. That gives five levels: -4, -2, 0, +2 and +4 units. The trellis state holds the two previous bits.

Branch costs are squared errors. Survivor paths are held in a register-exchange array that is `DEPTH` bits deep. Both streams use valid/ready. A sample is taken when `in_valid` and `in_ready` are both high at a clock edge. A bit leaves when `out_valid` and `out_ready` are both high. `in_ready` is low exactly when an output bit is waiting and the sink is not taking it. While a bit is held, `out_bit` does not change. To drain the last bits of a record, the source must push `DEPTH` further samples.

Top module: `pr2_viterbi_detector`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves `out_valid` low and `in_ready` high. The trellis starts as if the two bits before the first sample were both 0 (amplitude -1).
- R2: The first `DEPTH` accepted samples produce no output. The output for sample k is presented in the cycle after sample k+`DEPTH` is accepted.
- R3: For a noiseless sample stream built with the level formula above, the detected bits equal the written bits, in order.
- R4: With additive noise of magnitude at most `STEP/2 - 2` on every sample, the detected bits still equal the written bits.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_bit` is held stable.
- R6: Cycles in which `in_valid` is low, or in which the sample is not accepted, do not change the detected stream. The output is identical to that of a gap-free run.
- R7: Path metrics never overflow. After a long run of full-scale alternating samples (+max, -max) that fits no trellis path, clean samples are decoded correctly from the third clean sample on.
- R8: Exactly one bit is emitted for each accepted sample beyond the first `DEPTH`. With `out_ready` held high and continuous input, one bit leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Equalized sample present |
| in_ready | output | 1 | Detector can take a sample this cycle |
| in_sample | input | SW | Signed two's-complement equalized sample |
| out_valid | output | 1 | Detected bit present |
| out_ready | input | 1 | Sink takes the detected bit this cycle |
| out_bit | output | 1 | Detected channel bit (1 = +1, 0 = -1) |

## Verification
Two things can fall in the same cycle: a new sample is accepted, and the waiting output bit is drained. When both happen, the register must reload with the next decision rather than clear, and no bit may be lost or repeated. The bench provokes this by holding `out_ready` high under continuous input. It also provokes it by mixing input gaps with sink stalls on independent patterns, so that acceptance and draining coincide in some cycles and are apart in others. Each run is judged by comparing every emitted bit, in order, against the written bit sequence. The bench also checks that the total count equals the accepted count minus `DEPTH`, and that the first bit appears right after the (`DEPTH`+1)-th acceptance.

// File: rtl/pr2_pkg.sv
package pr2_pkg;
  localparam int NUM_STATES = 4;
  localparam int NUM_LEVELS = 5;

  // Noiseless sample for a level index (sum u + 2*b1 + b0 in 0..4).
  function automatic int level_value(input int idx, input int step);
    return (2 * idx - 4) * step;
  endfunction
endpackage

// File: rtl/pr2_branch_unit.sv
module pr2_branch_unit #(
  parameter int SW  = 8,
  parameter int STEP = 16,
  localparam int DW  = SW + 2,
  localparam int BMW = 2 * DW
) (
  input  logic signed [SW-1:0] sample,
  output logic [BMW-1:0]       bm [pr2_pkg::NUM_LEVELS]
);
  logic signed [DW-1:0] s_ext;
  assign s_ext = {{2{sample[SW-1]}}, sample};

  for (genvar l = 0; l < pr2_pkg::NUM_LEVELS; l++) begin : g_level
    localparam int LV = pr2_pkg::level_value(l, STEP);
    logic signed [DW-1:0]    err;
    logic signed [2*DW-1:0]  sq;
    assign err   = s_ext - DW'(LV);
    assign sq    = err * err;
    assign bm[l] = $unsigned(sq);
  end
endmodule

// File: rtl/pr2_acs_cell.sv
module pr2_acs_cell #(
  parameter int PMW = 23,
  parameter int BMW = 20
) (
  input  logic [PMW-1:0] pm_a,
  input  logic [PMW-1:0] pm_b,
  input  logic [PMW-1:0] pm_floor,
  input  logic [BMW-1:0] bm_a,
  input  logic [BMW-1:0] bm_b,
  output logic [PMW-1:0] pm_next,
  output logic           pick_b
);
  logic [PMW-1:0] cand_a, cand_b;
  assign cand_a  = pm_a - pm_floor + PMW'(bm_a);
  assign cand_b  = pm_b - pm_floor + PMW'(bm_b);
  assign pick_b  = cand_b < cand_a;
  assign pm_next = pick_b ? cand_b : cand_a;
endmodule

// File: rtl/pr2_min_select.sv
module pr2_min_select #(
  parameter int PMW = 23
) (
  input  logic [PMW-1:0] pm [pr2_pkg::NUM_STATES],
  output logic [1:0]     best_idx,
  output logic [PMW-1:0] best_pm
);
  always_comb begin
    best_idx = 2'd0;
    best_pm  = pm[0];
    for (int i = 1; i < pr2_pkg::NUM_STATES; i++) begin
      if (pm[i] < best_pm) begin
        best_idx = 2'(i);
        best_pm  = pm[i];
      end
    end
  end
endmodule

// File: rtl/pr2_viterbi_detector.sv
module pr2_viterbi_detector #(
  parameter int SW    = 8,
  parameter int STEP  = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  import pr2_pkg::*;

  localparam int DW    = SW + 2;
  localparam int BMW   = 2 * DW;
  localparam int PMW   = BMW + 3;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [PMW-1:0] PM_START = PMW'(1) << (BMW + 1);
  localparam logic [PMW-1:0] PM_LIMIT = PMW'(1) << (BMW + 2);

  logic [PMW-1:0]   pm_q   [NUM_STATES];
  logic [PMW-1:0]   pm_d   [NUM_STATES];
  logic [DEPTH-1:0] surv_q [NUM_STATES];
  logic [DEPTH-1:0] surv_d [NUM_STATES];
  logic [NUM_STATES-1:0] pick_b;
  logic [BMW-1:0]   bm [NUM_LEVELS];
  logic [1:0]       best_idx;
  logic [PMW-1:0]   best_pm;
  logic [CW-1:0]    fill_q;
  logic             accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pr2_branch_unit #(.SW(SW), .STEP(STEP)) u_branch (
    .sample (signed'(in_sample)),
    .bm     (bm)
  );

  pr2_min_select #(.PMW(PMW)) u_best (
    .pm       (pm_q),
    .best_idx (best_idx),
    .best_pm  (best_pm)
  );

  // Next state ns = {u, b1}; predecessors {b1, 0} and {b1, 1}.
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    localparam int PA = 2 * (s % 2);
    localparam int LA = (s / 2) + 2 * (s % 2);
    localparam logic NEW_BIT = 1'(s / 2);

    pr2_acs_cell #(.PMW(PMW), .BMW(BMW)) u_acs (
      .pm_a     (pm_q[PA]),
      .pm_b     (pm_q[PA+1]),
      .pm_floor (best_pm),
      .bm_a     (bm[LA]),
      .bm_b     (bm[LA+1]),
      .pm_next  (pm_d[s]),
      .pick_b   (pick_b[s])
    );

    assign surv_d[s] = pick_b[s] ? {surv_q[PA+1][DEPTH-2:0], NEW_BIT}
                                 : {surv_q[PA][DEPTH-2:0], NEW_BIT};

    always_ff @(posedge clk) begin
      if (rst) begin
        pm_q[s]   <= (s == 0) ? '0 : PM_START;
        surv_q[s] <= '0;
      end else if (accept) begin
        pm_q[s]   <= pm_d[s];
        surv_q[s] <= surv_d[s];
      end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      pm_q[s] < PM_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (accept && fill_q != CW'(DEPTH)) fill_q <= fill_q + 1'b1;
      if (accept && fill_q == CW'(DEPTH)) begin
        out_valid <= 1'b1;
        out_bit   <= surv_q[best_idx][DEPTH-1];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_stall_blocks_input_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_output_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  p_silent_while_filling_r2: assert property (@(posedge clk) disable iff (rst)
    (fill_q < CW'(DEPTH)) |-> !out_valid);

  p_drain_empties_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !accept) |=> !out_valid);
endmodule

// File: tb/test_pr2_viterbi_detector.sv
module test_pr2_viterbi_detector;
  localparam int SW    = 8;
  localparam int STEP  = 16;
  localparam int DEPTH = 16;
  localparam int MAXN  = 700;
  localparam int SMAX  = (1 << (SW - 1)) - 1;
  localparam int SMIN  = -(1 << (SW - 1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_sample = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_bit;

  int vectors  = 0;
  int failures = 0;
  int cycles   = 0;
  int unsigned seed = 32'h1234_5678;
  bit bits_a [MAXN];
  int samp_a [MAXN];

  always #2 clk = ~clk;

  pr2_viterbi_detector #(.SW(SW), .STEP(STEP), .DEPTH(DEPTH)) i_pr2_viterbi_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Build bits and samples; samples in [g_lo, g_hi) are full-scale alternating.
  task automatic build(input int n, input int noise, input int g_lo, input int g_hi);
    bit p1 = 1'b0, p2 = 1'b0;
    for (int k = 0; k < n; k++) begin
      bit b = next_rand() % 2;
      int idx = int'(b) + 2 * int'(p1) + int'(p2);
      int s = (2 * idx - 4) * STEP;
      if (noise > 0) s += int'(next_rand() % (2 * noise + 1)) - noise;
      if (k >= g_lo && k < g_hi) s = (k % 2 == 0) ? SMAX : SMIN;
      if (s > SMAX) s = SMAX;
      if (s < SMIN) s = SMIN;
      bits_a[k] = b; samp_a[k] = s;
      p2 = p1; p1 = b;
    end
  endtask

  // Stream n samples; check bits with index >= chk_from, latency and count.
  task automatic run_stream(input int n, input bit gaps, input bit stalls,
                            input int chk_from, input string req);
    int in_idx = 0, out_idx = 0, t = 0, first_at = -1;
    do_reset();
    while ((in_idx < n || out_valid) && t < 20000) begin
      @(negedge clk);
      out_ready = stalls ? (t % 5 != 3) : 1'b1;
      in_valid  = (in_idx < n) && !(gaps && (t % 7 == 2));
      in_sample = (in_idx < n) ? SW'(samp_a[in_idx]) : '0;
      #1;
      if (out_valid && first_at < 0) first_at = in_idx;
      if (out_valid && out_ready) begin
        if (out_idx >= chk_from)
          check(out_bit == bits_a[out_idx], req, int'(out_bit), int'(bits_a[out_idx]));
        out_idx++;
      end
      if (in_valid && in_ready) in_idx++;
      t++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(first_at == DEPTH + 1, "R2 first output after DEPTH+1 accepts", first_at, DEPTH + 1);
    check(out_idx == n - DEPTH, "R8 one bit per accepted sample", out_idx, n - DEPTH);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_clean_stream();
    build(200, 0, 0, 0);
    run_stream(200, 1'b0, 1'b0, 0, "R3 noiseless decode");
    build(120, 0, 0, 0);
    run_stream(120, 1'b0, 1'b0, 0, "R8 full-rate decode");
  endtask

  task automatic t_noisy_stream();
    build(300, STEP / 2 - 2, 0, 0);
    run_stream(300, 1'b0, 1'b0, 0, "R4 noisy decode");
  endtask

  task automatic t_flow_control();
    int stall_seen = 0;
    build(150, 3, 0, 0);
    run_stream(150, 1'b1, 1'b1, 0, "R6 gaps and stalls");
    build(60, 0, 0, 0);
    do_reset();
    out_ready = 1'b0;
    for (int k = 0; k < DEPTH + 1; k++) begin
      in_valid = 1'b1; in_sample = SW'(samp_a[k]);
      @(negedge clk);
    end
    in_valid = 1'b1; in_sample = SW'(samp_a[DEPTH + 1]);
    #1;
    check(out_valid == 1'b1, "R5 bit waiting", int'(out_valid), 1);
    check(in_ready == 1'b0, "R5 input blocked while held", int'(in_ready), 0);
    check(out_bit == bits_a[0], "R5 held bit value", int'(out_bit), int'(bits_a[0]));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      if (out_valid && !in_ready && out_bit == bits_a[0]) stall_seen++;
    end
    check(stall_seen == 4, "R5 stable across stall", stall_seen, 4);
    in_valid = 1'b0;
  endtask

  task automatic t_saturation();
    build(600, 0, 20, 420);
    run_stream(600, 1'b0, 1'b0, 422, "R7 recovery after full-scale run");
  endtask

  initial begin
    t_reset_state();
    t_clean_stream();
    t_noisy_stream();
    t_flow_control();
    t_saturation();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end
endmodule